// File: doc/BRIEF.md
# Four-Channel Audio Mixer with Logarithmic Volume

The block combines four signed 16-bit audio streams that share one sample strobe into a single 16-bit stream. Each channel is scaled by its own attenuation, picked by a 7-bit volume code from a logarithmically stepped gain ladder. The four scaled samples are added and clamped to the 16-bit range. A master attenuation from the same ladder is then applied to the clamped sum.

A host writes volume codes through a small write port that selects either a channel or the master. When fade is enabled, a channel does not jump to a newly written code. Its active index walks toward the target one entry at a time, advancing every programmable number of sample strobes. Codes whose two low bits are zero form a coarse 32-level ladder, for hosts that only need coarse control.

Top module: `quad_mix_vol`

## Requirements
- R1: After reset, mix_vld is 0 and mix_out is 0. Every channel code is 0 (unity gain). The master code is MASTER_RST, which defaults to 45 (about -3.96 dB).
- R2: Volume code k selects an unsigned gain with 15 fraction bits. The gain is g(0)=32768 and g(k)=g(k-1)-(g(k-1)>>s), where s is 7, 6, 5 or 4 when k-1 lies in 0..31, 32..63, 64..95 or 96..127 respectively.
- R3: Each channel contributes (sample*g + 16384) >>> 15 to the sum, computed as an arithmetic shift.
- R4: The sum of the four channel contributions is clamped to the range -32768..32767.
- R5: The master gain multiplies the clamped sum using the same rounding as R3, so it is applied after clamping, never per channel.
- R6: A strobe sampled at rising edge n updates mix_out, and raises mix_vld for one cycle, at edge n+2. Between updates, mix_out holds its value.
- R7: A write applies vol_code to channel vol_sel when vol_sel is 0..3, and to the master when vol_sel is 4. With fade off, a channel write takes effect for strobes sampled two or more edges after the write edge.
- R8: With fade on, a channel's active index moves by one toward its target, up or down, on every strobe for which fade_div strobes have already passed since the last step. The strobe that causes a step still uses the old index.
- R9: Writes with vol_sel 5, 6 or 7 change no gain.
- R10: Codes 0, 4, 8, ... 124 form a coarse 32-level ladder. The first coarse step, code 4, gives gain 31756 (about -0.27 dB).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe shared by all channels |
| smp_data | input | 64 | Four signed samples; channel c sits at bits 16c+15..16c |
| vol_wr | input | 1 | Volume write enable |
| vol_sel | input | 3 | Write target: 0..3 selects a channel, 4 selects the master |
| vol_code | input | 7 | Volume code to write |
| fade_en | input | 1 | Enables stepwise channel volume changes |
| fade_div | input | 8 | Number of strobes between fade steps, minus one |
| mix_vld | output | 1 | One-cycle pulse when mix_out updates |
| mix_out | output | 16 | Mixed, clamped and master-scaled sample |

## Verification
Several kinds of stimulus are applied:
- Vectors of mixed-sign samples at unity gain, which show whether the four channels are added exactly.
- Vectors of four large equal samples of either sign, which reveal missing or wrong clamping.
- Large samples combined with a non-unity master, which separate applying the master after the clamp from applying it per channel.
- Coarse and fine codes on samples near full scale and near one LSB, which probe the gain ladder and the rounding of negative products.
- A fade sequence up and then down, which exposes wrong step timing, wrong direction and the index used on the stepping strobe.
- Writes with the unused selects, which show aliasing onto the master or a channel.

// File: rtl/mixv_pkg.sv
package mixv_pkg;
  localparam int SMP_W     = 16;
  localparam int GAIN_W    = 16;
  localparam int CODE_W    = 7;
  localparam int NLVL      = 1 << CODE_W;
  localparam int GAIN_FRAC = GAIN_W - 1;
  localparam int PROD_W    = SMP_W + GAIN_W + 1;

  // attenuation shift for the step leaving index i: finer near unity
  function automatic int step_shift(input int i);
    int quarter;
    quarter = i / (NLVL / 4);
    return 7 - quarter;
  endfunction

  function automatic logic [GAIN_W-1:0] gain_of(input int k);
    int g;
    g = 1 << GAIN_FRAC;
    for (int i = 0; i < k; i++) g = g - (g >>> step_shift(i));
    return GAIN_W'(g);
  endfunction

  // signed sample times unsigned gain, rounded half up, back to sample width
  function automatic logic signed [SMP_W-1:0] scale_rnd(
    input logic signed [SMP_W-1:0] s,
    input logic [GAIN_W-1:0]       g
  );
    logic signed [PROD_W-1:0] p;
    p = s * $signed({1'b0, g});
    p = p + PROD_W'(1 << (GAIN_FRAC - 1));
    p = p >>> GAIN_FRAC;
    return p[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/mixv_gain_rom.sv
module mixv_gain_rom
  import mixv_pkg::*;
(
  input  logic [CODE_W-1:0] idx,
  output logic [GAIN_W-1:0] gain
);
  logic [GAIN_W-1:0] tbl [NLVL];

  for (genvar k = 0; k < NLVL; k++) begin : g_ent
    localparam logic [GAIN_W-1:0] GV = gain_of(k);
    assign tbl[k] = GV;
  end

  assign gain = tbl[idx];
endmodule

// File: rtl/mixv_vol_ramp.sv
module mixv_vol_ramp
  import mixv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              fade_en,
  input  logic              step_tick,
  output logic [CODE_W-1:0] cur_idx
);
  logic [CODE_W-1:0] tgt_q, tgt_d;
  logic [CODE_W-1:0] cur_q, cur_d;

  always_comb begin
    tgt_d = wr_hit ? wr_code : tgt_q;
    cur_d = cur_q;
    if (!fade_en) begin
      cur_d = tgt_q;
    end else if (step_tick) begin
      if (cur_q < tgt_q)      cur_d = cur_q + 1'b1;
      else if (cur_q > tgt_q) cur_d = cur_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      cur_q <= '0;
    end else begin
      tgt_q <= tgt_d;
      cur_q <= cur_d;
    end
  end

  assign cur_idx = cur_q;

  // R8: while fading, the active index never moves by more than one entry
  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fade_en) |-> (cur_q == $past(cur_q) || cur_q == $past(cur_q) + 1'b1 ||
                        cur_q == $past(cur_q) - 1'b1));

  // R8: a rising ramp never passes its target
  a_r8_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fade_en) && $past(cur_q) <= $past(tgt_q)) |-> cur_q <= $past(tgt_q));
endmodule

// File: rtl/mixv_mix_sat.sv
module mixv_mix_sat
  import mixv_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NCH*SMP_W-1:0]     prod_flat,
  output logic signed [SMP_W-1:0]  sat_sum
);
  localparam int SUM_W = SMP_W + $clog2(NCH) + 1;
  localparam logic signed [SUM_W-1:0] MAXV = {{(SUM_W-SMP_W+1){1'b0}}, {(SMP_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MINV = {{(SUM_W-SMP_W+1){1'b1}}, {(SMP_W-1){1'b0}}};

  logic signed [SUM_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int c = 0; c < NCH; c++) begin
      acc = acc + SUM_W'($signed(prod_flat[c*SMP_W +: SMP_W]));
    end
    if (acc > MAXV)      sat_sum = {1'b0, {(SMP_W-1){1'b1}}};
    else if (acc < MINV) sat_sum = {1'b1, {(SMP_W-1){1'b0}}};
    else                 sat_sum = acc[SMP_W-1:0];
  end
endmodule

// File: rtl/quad_mix_vol.sv
module quad_mix_vol
  import mixv_pkg::*;
#(
  parameter  int NCH        = 4,
  parameter  int FDIV_W     = 8,
  parameter  int MASTER_RST = 45,
  localparam int SEL_W      = $clog2(NCH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_vld,
  input  logic [NCH*SMP_W-1:0]   smp_data,
  input  logic                   vol_wr,
  input  logic [SEL_W-1:0]       vol_sel,
  input  logic [CODE_W-1:0]      vol_code,
  input  logic                   fade_en,
  input  logic [FDIV_W-1:0]      fade_div,
  output logic                   mix_vld,
  output logic [SMP_W-1:0]       mix_out
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // fade step pacing
  logic [FDIV_W-1:0] fcnt_q, fcnt_d;
  logic              fade_tick;

  always_comb begin
    fade_tick = fade_en && smp_vld && (fcnt_q == fade_div);
    fcnt_d    = fcnt_q;
    if (!fade_en)     fcnt_d = '0;
    else if (smp_vld) fcnt_d = fade_tick ? '0 : fcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) fcnt_q <= '0;
    else        fcnt_q <= fcnt_d;
  end

  // per-channel volume, gain and rounded product
  logic [GAIN_W-1:0]    ch_gain [NCH];
  logic [NCH*SMP_W-1:0] prod_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CODE_W-1:0] idx;
    logic              hit;

    assign hit = vol_wr && (vol_sel == SEL_W'(c));

    mixv_vol_ramp u_ramp (
      .clk       (clk),
      .rst_n     (rst_s),
      .wr_hit    (hit),
      .wr_code   (vol_code),
      .fade_en   (fade_en),
      .step_tick (fade_tick),
      .cur_idx   (idx)
    );

    mixv_gain_rom u_rom (
      .idx  (idx),
      .gain (ch_gain[c])
    );

    assign prod_d[c*SMP_W +: SMP_W] =
      scale_rnd($signed(smp_data[c*SMP_W +: SMP_W]), ch_gain[c]);
  end

  // stage 1: products
  logic [NCH*SMP_W-1:0] prod_q, prod_n;
  logic                 s1_vld_q;

  always_comb prod_n = smp_vld ? prod_d : prod_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      prod_q   <= '0;
      s1_vld_q <= 1'b0;
    end else begin
      prod_q   <= prod_n;
      s1_vld_q <= smp_vld;
    end
  end

  // master volume register
  logic [CODE_W-1:0] mst_q, mst_d;
  logic [GAIN_W-1:0] mst_gain;

  always_comb mst_d = (vol_wr && vol_sel == SEL_W'(NCH)) ? vol_code : mst_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) mst_q <= CODE_W'(MASTER_RST);
    else        mst_q <= mst_d;
  end

  mixv_gain_rom u_mst_rom (
    .idx  (mst_q),
    .gain (mst_gain)
  );

  // stage 2: sum, clamp, master
  logic signed [SMP_W-1:0] sat_sum;

  mixv_mix_sat #(.NCH(NCH)) u_sum (
    .prod_flat (prod_q),
    .sat_sum   (sat_sum)
  );

  logic [SMP_W-1:0] out_q, out_d;
  logic             vld_q;

  always_comb out_d = s1_vld_q ? scale_rnd(sat_sum, mst_gain) : out_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= out_d;
      vld_q <= s1_vld_q;
    end
  end

  assign mix_out = out_q;
  assign mix_vld = vld_q;

  // magnitudes for the attenuation check
  logic signed [SMP_W:0] ext_out, ext_sum;
  logic        [SMP_W:0] mag_out, mag_sum;

  always_comb begin
    ext_out = {out_q[SMP_W-1], out_q};
    ext_sum = {sat_sum[SMP_W-1], sat_sum};
    mag_out = (ext_out < 0) ? -ext_out : ext_out;
    mag_sum = (ext_sum < 0) ? -ext_sum : ext_sum;
  end

  // R6: an output pulse only follows a strobe two edges earlier
  a_r6_vld_latency: assert property (@(posedge clk) disable iff (!rst_s)
    mix_vld |-> $past(smp_vld, 2));

  // R6: output holds between updates
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !mix_vld |-> $stable(mix_out));

  // R5: master stage never amplifies the clamped sum
  a_r5_attenuates: assert property (@(posedge clk) disable iff (!rst_s)
    mix_vld |-> mag_out <= $past(mag_sum));

  // R9: unused selects leave the master code untouched
  a_r9_master_ignored: assert property (@(posedge clk) disable iff (!rst_s)
    $past(vol_wr && vol_sel > SEL_W'(NCH)) |-> mst_q == $past(mst_q));
endmodule

// File: tb/quad_mix_vol_tb_top.sv
module quad_mix_vol_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic signed [15:0] s0, s1, s2, s3;
    logic [6:0]         c0, c1, c2, c3, cm;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'sd0,      16'sd0,      16'sd0,     16'sd0,      7'd0,   7'd0,  7'd0,  7'd0,   7'd0},
    '{16'sd1000,  -16'sd2000,   16'sd3000, -16'sd500,    7'd0,   7'd0,  7'd0,  7'd0,   7'd0},
    '{16'sd20000,  16'sd20000,  16'sd20000, 16'sd20000,  7'd0,   7'd0,  7'd0,  7'd0,   7'd0},
    '{-16'sd20000,-16'sd20000, -16'sd20000,-16'sd20000,  7'd0,   7'd0,  7'd0,  7'd0,   7'd0},
    '{16'sd30000,  16'sd30000,  16'sd30000, 16'sd30000,  7'd0,   7'd0,  7'd0,  7'd0,   7'd45},
    '{16'sd32767,  16'sd0,      16'sd0,     16'sd0,      7'd4,   7'd0,  7'd0,  7'd0,   7'd0},
    '{16'sd12345, -16'sd23456,  16'sd7777, -16'sd1,      7'd8,   7'd36, 7'd64, 7'd124, 7'd20},
    '{16'sd1,     -16'sd1,      16'sd1,    -16'sd1,      7'd127, 7'd127,7'd127,7'd127, 7'd30}
  };

  logic        clk;
  logic        rst_n;
  logic        smp_vld;
  logic [63:0] smp_data;
  logic        vol_wr;
  logic [2:0]  vol_sel;
  logic [6:0]  vol_code;
  logic        fade_en;
  logic [7:0]  fade_div;
  logic        mix_vld;
  logic [15:0] mix_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  quad_mix_vol dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .vol_wr(vol_wr), .vol_sel(vol_sel), .vol_code(vol_code),
    .fade_en(fade_en), .fade_div(fade_div),
    .mix_vld(mix_vld), .mix_out(mix_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R6: actual cycles %0d expected fewer than 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // model of the requirements
  function automatic int b_gain(int k);
    int g = 32768;
    for (int i = 0; i < k; i++) g = g - (g >>> ((i < 32) ? 7 : (i < 64) ? 6 : (i < 96) ? 5 : 4));
    return g;
  endfunction

  function automatic int b_scale(int s, int g);
    return (s * g + 16384) >>> 15;
  endfunction

  function automatic int b_clamp(int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int b_mix(int s0, int s1, int s2, int s3,
                               int c0, int c1, int c2, int c3, int cm);
    int t;
    t = b_scale(s0, b_gain(c0)) + b_scale(s1, b_gain(c1)) +
        b_scale(s2, b_gain(c2)) + b_scale(s3, b_gain(c3));
    return b_scale(b_clamp(t), b_gain(cm));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int code);
    @(negedge clk);
    vol_wr = 1'b1; vol_sel = 3'(sel); vol_code = 7'(code);
    @(negedge clk);
    vol_wr = 1'b0;
  endtask

  // strobe, then sample at the negedge after the second rising edge
  task automatic strobe(input int s0, input int s1, input int s2, input int s3,
                        input int exp, input string req);
    int held;
    @(negedge clk);
    smp_vld = 1'b1;
    smp_data = {16'(s3), 16'(s2), 16'(s1), 16'(s0)};
    @(negedge clk);
    smp_vld = 1'b0;
    @(negedge clk);
    chk(mix_vld === 1'b1, "R6 vld pulse", int'(mix_vld), 1);
    chk($signed(mix_out) == exp, req, int'($signed(mix_out)), exp);
    held = int'($signed(mix_out));
    @(negedge clk);
    chk(mix_vld === 1'b0 && int'($signed(mix_out)) == held, "R6 hold",
        int'($signed(mix_out)), held);
  endtask

  initial begin
    int e;
    rst_n = 1'b0; smp_vld = 1'b0; smp_data = '0; vol_wr = 1'b0;
    vol_sel = '0; vol_code = '0; fade_en = 1'b0; fade_div = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(mix_vld === 1'b0, "R1 reset vld", int'(mix_vld), 0);
    chk(mix_out === 16'd0, "R1 reset out", int'(mix_out), 0);
    e = b_scale(10000, b_gain(45));
    strobe(1000, 2000, 3000, 4000, e, "R1 reset gains");

    // vector table walk (R2 R3 R4 R5 R7 R10)
    for (int v = 0; v < NV; v++) begin
      wr(0, VECS[v].c0); wr(1, VECS[v].c1); wr(2, VECS[v].c2); wr(3, VECS[v].c3);
      wr(4, VECS[v].cm);
      e = b_mix(VECS[v].s0, VECS[v].s1, VECS[v].s2, VECS[v].s3,
                VECS[v].c0, VECS[v].c1, VECS[v].c2, VECS[v].c3, VECS[v].cm);
      strobe(VECS[v].s0, VECS[v].s1, VECS[v].s2, VECS[v].s3, e,
             $sformatf("R2 R3 R4 R5 R7 R10 vector %0d", v));
    end

    // R10 coarse first step gain
    chk(b_gain(4) == 31756, "R10 model coarse step", b_gain(4), 31756);

    // R9 unused selects ignored
    wr(5, 0); wr(6, 0); wr(7, 0);
    e = b_mix(10000, 10000, 10000, 10000, 127, 127, 127, 127, 30);
    strobe(10000, 10000, 10000, 10000, e, "R9 unused select");

    // R8 fade ramp up then down
    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 0);
    @(negedge clk);
    fade_div = 8'd1;
    fade_en = 1'b1;
    wr(0, 3);
    begin
      int up_idx [8] = '{0, 0, 1, 1, 2, 2, 3, 3};
      for (int k = 0; k < 8; k++) begin
        e = b_scale(20000, b_gain(up_idx[k]));
        strobe(20000, 0, 0, 0, e, $sformatf("R8 fade up step %0d", k));
      end
    end
    wr(0, 1);
    begin
      int dn_idx [5] = '{3, 3, 2, 2, 1};
      for (int k = 0; k < 5; k++) begin
        e = b_scale(20000, b_gain(dn_idx[k]));
        strobe(20000, 0, 0, 0, e, $sformatf("R8 fade down step %0d", k));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule